// File: doc/BRIEF.md
# External Interrupt Sense Latch Unit

This block receives one non-maskable interrupt line and sixteen general external interrupt lines from package pins. Every line is brought into the clock domain through a two-stage synchronizer. Each line is then classified by its programmed sense: a level, a falling edge, a rising edge or both edges. A qualifying event latches a pending flag, and each pending flag is presented directly as an active-high level request to a downstream interrupt controller. The unit does not arbitrate, vector or mask requests.

Software programs and observes the unit through a flat 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data, and every write takes effect on the clock edge where the strobe is high. In level mode a flag tracks the synchronized pin and drops by itself when the source releases. In edge mode a flag stays set until software writes a one to its bit in the clear register. Clear writes have no effect on level-mode flags. When a new edge and a clear arrive in the same cycle, the new edge wins.

Each input is handled by a channel state machine with two states, `CH_IDLE` (no request) and `CH_PEND` (request asserted). Its transitions are:

- `CH_IDLE -> CH_PEND`: in an edge mode, on a detected edge of the selected polarity; in level mode, while the synchronized pin is low.
- `CH_PEND -> CH_IDLE`: in an edge mode, on a clear write that does not coincide with a new edge; in level mode, once the synchronized pin is high.
- All other cases hold the current state.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset both sense registers read 0, which means a falling-edge non-maskable line and low-level general lines. No request is asserted while the pins idle high.
- R2: The non-maskable sense bit is bit 0 at offset 0x08. A value of 0 latches the request on a falling edge and a value of 1 on a rising edge. An edge of the other polarity latches nothing.
- R3: The non-maskable flag stays set until a write to offset 0x04 with bit 0 set. A write there with bit 0 clear leaves the flag unchanged.
- R4: Offset 0x18 holds a 2-bit sense field per general line, with line n at bits [2n+1:2n]. The codes are 0 low level, 1 falling edge, 2 rising edge and 3 both edges. The register reads back as written.
- R5: In low-level mode a flag is set while the synchronized pin is low and clears by itself when the pin returns high. A clear write to that bit has no effect.
- R6: In falling, rising and both-edge modes a flag latches only on edges of the selected polarity.
- R7: Writing 1 to bit n at offset 0x14 clears edge-mode flag n only. Flags whose bits are written as 0 are unaffected.
- R8: If an edge is detected in the same cycle as a clear write for that line, the flag remains set.
- R9: Offset 0x00 reads the non-maskable flag in bit 0 and offset 0x10 reads general flag n in bit n. Offsets 0x04, 0x14 and unmapped offsets read 0.
- R10: A pin change sampled at one rising edge first shows on the request output after the third rising edge, and not after the second.
- R11: Each request output equals its status flag as an active-high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| nmi_pin | input | 1 | Raw non-maskable interrupt line |
| irq_pins | input | N_IRQ (16) | Raw general interrupt lines |
| nmi_req | output | 1 | Non-maskable request, active high |
| irq_req | output | N_IRQ (16) | General requests, active high |

## Verification
Several lines are driven low and then high together while set to falling, rising and both-edge modes. This separates the three edge decoders in one step, because each mode yields a different set of latched flags. A held-low pin in level mode is checked for self-clearing and for ignoring clears, as opposed to the sticky edge flags. The non-maskable line is exercised under both polarities to show that the opposite edge is discarded. A clear aligned with a fresh edge shows the set-over-clear priority. A check after two and after three edges pins down the synchronizer latency.

// File: rtl/eil_pkg.sv
package eil_pkg;
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'd0,
        SENSE_FALL = 2'd1,
        SENSE_RISE = 2'd2,
        SENSE_BOTH = 2'd3
    } sense_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } ch_state_e;

    localparam logic [7:0] OFF_NMI_STAT = 8'h00;
    localparam logic [7:0] OFF_NMI_CLR  = 8'h04;
    localparam logic [7:0] OFF_NMI_SNS  = 8'h08;
    localparam logic [7:0] OFF_IRQ_STAT = 8'h10;
    localparam logic [7:0] OFF_IRQ_CLR  = 8'h14;
    localparam logic [7:0] OFF_IRQ_SNS  = 8'h18;
endpackage

// File: rtl/eil_sync.sv
module eil_sync #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] stage1;

    // Reset to the idle-high level so that no edge is seen when reset releases.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '1;
            cur    <= '1;
            prev   <= '1;
        end else begin
            stage1 <= din;
            cur    <= stage1;
            prev   <= cur;
        end
    end
endmodule

// File: rtl/eil_chan.sv
module eil_chan
    import eil_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_e mode,
    input  logic   cur,
    input  logic   prev,
    input  logic   clr,
    output logic   pend
);
    ch_state_e st, st_nxt;
    logic      hit;

    always_comb begin
        hit = 1'b0;
        unique case (mode)
            SENSE_LOW:  hit = 1'b0;
            SENSE_FALL: hit = prev & ~cur;
            SENSE_RISE: hit = cur & ~prev;
            SENSE_BOTH: hit = cur ^ prev;
        endcase
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            CH_IDLE: begin
                if (mode == SENSE_LOW) begin
                    if (!cur) st_nxt = CH_PEND;
                end else if (hit) begin
                    st_nxt = CH_PEND;
                end
            end
            CH_PEND: begin
                if (mode == SENSE_LOW) begin
                    if (cur) st_nxt = CH_IDLE;
                end else if (clr && !hit) begin
                    st_nxt = CH_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CH_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        pend = (st == CH_PEND);
    end
endmodule

// File: rtl/eil_regs.sv
module eil_regs
    import eil_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int N_IRQ  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 nmi_flag,
    input  logic [N_IRQ-1:0]     irq_flag,
    output logic                 nmi_rise_sel,
    output logic [2*N_IRQ-1:0]   irq_mode,
    output logic                 nmi_clr,
    output logic [N_IRQ-1:0]     irq_clr
);
    localparam logic [ADDR_W-1:0] A_NMI_STAT = ADDR_W'(OFF_NMI_STAT);
    localparam logic [ADDR_W-1:0] A_NMI_CLR  = ADDR_W'(OFF_NMI_CLR);
    localparam logic [ADDR_W-1:0] A_NMI_SNS  = ADDR_W'(OFF_NMI_SNS);
    localparam logic [ADDR_W-1:0] A_IRQ_STAT = ADDR_W'(OFF_IRQ_STAT);
    localparam logic [ADDR_W-1:0] A_IRQ_CLR  = ADDR_W'(OFF_IRQ_CLR);
    localparam logic [ADDR_W-1:0] A_IRQ_SNS  = ADDR_W'(OFF_IRQ_SNS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_rise_sel <= 1'b0;
            irq_mode     <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_NMI_SNS) nmi_rise_sel <= bus_wdata[0];
            if (bus_addr == A_IRQ_SNS) irq_mode     <= bus_wdata[2*N_IRQ-1:0];
        end
    end

    always_comb begin
        nmi_clr = bus_we && (bus_addr == A_NMI_CLR) && bus_wdata[0];
        irq_clr = (bus_we && (bus_addr == A_IRQ_CLR)) ? bus_wdata[N_IRQ-1:0] : '0;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_NMI_STAT)      bus_rdata = {31'd0, nmi_flag};
        else if (bus_addr == A_NMI_SNS)  bus_rdata = {31'd0, nmi_rise_sel};
        else if (bus_addr == A_IRQ_STAT) bus_rdata = 32'(irq_flag);
        else if (bus_addr == A_IRQ_SNS)  bus_rdata = 32'(irq_mode);
    end
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
    import eil_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int N_IRQ  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              nmi_pin,
    input  logic [N_IRQ-1:0]  irq_pins,
    output logic              nmi_req,
    output logic [N_IRQ-1:0]  irq_req
);
    localparam int N_IN = N_IRQ + 1;

    logic [N_IN-1:0]      s_cur, s_prev;
    logic                 nmi_rise_sel, nmi_clr;
    logic [2*N_IRQ-1:0]   irq_mode;
    logic [N_IRQ-1:0]     irq_clr;

    eil_sync #(.W(N_IN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({nmi_pin, irq_pins}),
        .cur  (s_cur),
        .prev (s_prev)
    );

    eil_regs #(.ADDR_W(ADDR_W), .N_IRQ(N_IRQ)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .nmi_flag    (nmi_req),
        .irq_flag    (irq_req),
        .nmi_rise_sel(nmi_rise_sel),
        .irq_mode    (irq_mode),
        .nmi_clr     (nmi_clr),
        .irq_clr     (irq_clr)
    );

    eil_chan u_nmi (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (nmi_rise_sel ? SENSE_RISE : SENSE_FALL),
        .cur  (s_cur[N_IRQ]),
        .prev (s_prev[N_IRQ]),
        .clr  (nmi_clr),
        .pend (nmi_req)
    );

    for (genvar i = 0; i < N_IRQ; i++) begin : g_ch
        eil_chan u_ch (
            .clk  (clk),
            .rst_n(rst_n),
            .mode (sense_e'(irq_mode[2*i +: 2])),
            .cur  (s_cur[i]),
            .prev (s_prev[i]),
            .clr  (irq_clr[i]),
            .pend (irq_req[i])
        );
    end
endmodule

// File: rtl/eil_checker.sv
module eil_checker
    import eil_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int N_IRQ  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [N_IRQ-1:0]   clr_bits,
    input logic [31:0]        bus_rdata,
    input logic               nmi_req,
    input logic [N_IRQ-1:0]   irq_req,
    input logic [2*N_IRQ-1:0] irq_mode
);
    logic nmi_clr_wr, irq_clr_wr;
    assign nmi_clr_wr = bus_we && (bus_addr == ADDR_W'(OFF_NMI_CLR)) && clr_bits[0];
    assign irq_clr_wr = bus_we && (bus_addr == ADDR_W'(OFF_IRQ_CLR));

    AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !nmi_clr_wr) |=> nmi_req); // R3

    for (genvar i = 0; i < N_IRQ; i++) begin : g_hold
        AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req[i] && (irq_mode[2*i +: 2] != 2'd0) && !(irq_clr_wr && clr_bits[i]))
            |=> irq_req[i]); // R7
    end

    AST_IRQ_STAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_IRQ_STAT)) |->
        (bus_rdata[N_IRQ-1:0] == irq_req && bus_rdata[31:N_IRQ] == '0)); // R9

    AST_NMI_STAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_NMI_STAT)) |->
        (bus_rdata == {31'd0, nmi_req})); // R11
endmodule

bind ext_irq_latch eil_checker #(.ADDR_W(ADDR_W), .N_IRQ(N_IRQ)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .clr_bits (bus_wdata[N_IRQ-1:0]),
    .bus_rdata(bus_rdata),
    .nmi_req  (nmi_req),
    .irq_req  (irq_req),
    .irq_mode (irq_mode)
);

// File: tb/ext_irq_latch_tb.sv
`timescale 1ns/1ps
module ext_irq_latch_tb;
    localparam int ADDR_W = 8;
    localparam int N_IRQ  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              nmi_pin = 1'b1;
    logic [N_IRQ-1:0]  irq_pins = '1;
    logic              nmi_req;
    logic [N_IRQ-1:0]  irq_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    ext_irq_latch #(.ADDR_W(ADDR_W), .N_IRQ(N_IRQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nmi_pin(nmi_pin),
        .irq_pins(irq_pins), .nmi_req(nmi_req), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 nmi_req", {31'd0, nmi_req}, 32'd0);
        check("R1 irq_req", 32'(irq_req), 32'd0);
        bus_read(8'h18, d); check("R1 irq sense", d, 32'd0);
        bus_read(8'h08, d); check("R1 nmi sense", d, 32'd0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        @(negedge clk); irq_pins[3] = 1'b0;
        wait_cyc(2); check("R10 not yet", 32'(irq_req), 32'd0);
        wait_cyc(1); check("R10 R5 level set", 32'(irq_req), 32'h8);
        bus_read(8'h10, d); check("R9 R11 status", d, 32'h8);
        bus_write(8'h14, 32'h8);
        wait_cyc(1); check("R5 clear ignored", 32'(irq_req), 32'h8);
        irq_pins[3] = 1'b1;
        wait_cyc(4); check("R5 self clear", 32'(irq_req), 32'd0);
    endtask

    task automatic t_nmi();
        logic [31:0] d;
        @(negedge clk); nmi_pin = 1'b0;
        wait_cyc(4); check("R2 falling latch", {31'd0, nmi_req}, 32'd1);
        bus_read(8'h00, d); check("R9 nmi status", d, 32'd1);
        bus_write(8'h04, 32'h2);
        check("R3 bit0 clear no effect", {31'd0, nmi_req}, 32'd1);
        nmi_pin = 1'b1;
        wait_cyc(4); check("R3 sticky", {31'd0, nmi_req}, 32'd1);
        bus_write(8'h04, 32'h1);
        check("R3 cleared", {31'd0, nmi_req}, 32'd0);
        bus_write(8'h08, 32'h1);
        bus_read(8'h08, d); check("R2 sense readback", d, 32'd1);
        nmi_pin = 1'b0;
        wait_cyc(4); check("R2 falling ignored", {31'd0, nmi_req}, 32'd0);
        nmi_pin = 1'b1;
        wait_cyc(4); check("R2 rising latch", {31'd0, nmi_req}, 32'd1);
        bus_write(8'h04, 32'h1);
        check("R3 cleared again", {31'd0, nmi_req}, 32'd0);
    endtask

    task automatic t_edges();
        logic [31:0] d;
        // line0 falling (1), line1 rising (2), line2 both (3)
        bus_write(8'h18, 32'h39);
        bus_read(8'h18, d); check("R4 sense readback", d, 32'h39);
        irq_pins[2:0] = 3'b000;
        wait_cyc(4); check("R6 after fall", 32'(irq_req), 32'h5);
        irq_pins[2:0] = 3'b111;
        wait_cyc(4); check("R6 after rise", 32'(irq_req), 32'h7);
        bus_write(8'h14, 32'h1);
        check("R7 clear bit0 only", 32'(irq_req), 32'h6);
        bus_write(8'h14, 32'h6);
        check("R7 clear rest", 32'(irq_req), 32'd0);
    endtask

    task automatic t_priority();
        irq_pins[2] = 1'b0;
        wait_cyc(4); check("R8 setup", 32'(irq_req), 32'h4);
        irq_pins[2] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = 8'h14; bus_we = 1'b1; bus_wdata = 32'h4;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        check("R8 set beats clear", 32'(irq_req), 32'h4);
        bus_write(8'h14, 32'h4);
        check("R7 clear after", 32'(irq_req), 32'd0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_read(8'h04, d); check("R9 clr reads 0", d, 32'd0);
        bus_read(8'h14, d); check("R9 clr reads 0", d, 32'd0);
        bus_read(8'h20, d); check("R9 unmapped", d, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(4);
        t_reset();
        t_level();
        t_nmi();
        t_edges();
        t_priority();
        t_unmapped();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule